// File: doc/BRIEF.md
# Scheduled Monitor Poller with Interrupt Pre-emption

This block is the master-side read controller that a monitor network router uses to collect readings from a group of slave monitors. The monitors sit behind a multiplexer or a shared address/data bus. The controller drives one read address and a one-cycle sample strobe. It then takes the returned reading from a single data input a fixed number of cycles later. Each reading is tagged with the address of its source and a priority bit, and the tagged word goes into a small synchronizing FIFO. A packetizer drains that FIFO.

Periodic monitors sit at the low addresses, from 0 to NUM_PER-1. Every INTERVAL cycles the controller walks them in ascending order. Typical settings are 200 cycles for delay monitors and 800 cycles for thermal monitors. Event-driven monitors sit at addresses NUM_PER to NUM_PER+NUM_IRQ-1, and each has its own request line. A request is latched and then served ahead of the remaining scheduled reads. The walk then continues from the monitor it would have read next.

Top module: `mon_poller`

## Requirements
- R1: While reset is held, monSample is 0, monAddr is 0 and fifoEmpty is 1.
- R2: A polling round begins every INTERVAL cycles. Two consecutive rounds start their first strobe exactly INTERVAL cycles apart, and a round reads addresses 0 to NUM_PER-1 in ascending order.
- R3: Each read is a single-cycle monSample pulse with monAddr valid in the same cycle. The value stored is the one on monData exactly READ_LAT cycles after the strobe cycle.
- R4: A one-cycle pulse on irqReq[i] causes one read of address NUM_PER+i, and that read is stored with priority bit 1. Scheduled reads are stored with priority bit 0.
- R5: When several requests are pending, the lowest index is served first. A pending request clears only when its value is written into the FIFO.
- R6: A request that arrives during a round is served before the next scheduled read. The round then resumes at the following monitor, and no scheduled read is skipped.
- R7: While the FIFO is full, the controller holds the captured value and monAddr, issues no new strobe and drops nothing. Rounds that fall due during the stall are merged into one round that runs afterwards.
- R8: fifoData has the priority bit at the most significant position, the ADDR_W-bit monitor address below it, and the DATA_W-bit reading in the low bits. Entries leave in write order while fifoEmpty is 0, and each cycle with fifoPop high removes one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_IRQ | One request pulse line per event-driven monitor |
| monSample | output | 1 | One-cycle read strobe to the addressed monitor |
| monAddr | output | ADDR_W | Address of the monitor being read |
| monData | input | DATA_W | Reading returned through the multiplexer or bus |
| fifoPop | input | 1 | Removes the head entry of the FIFO |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoData | output | 1+ADDR_W+DATA_W | Head entry: {priority, address, reading} |

## Verification
The bench model of the monitor drives the correct reading for only one cycle. A controller that captures one cycle early or late therefore stores the inverted value and fails the data check. Two requests are raised in the middle of a scheduled read. A design with the wrong arbitration order, with no pre-emption, or that skips the interrupted slot on resume produces a different order of addresses. The bench also leaves the FIFO undrained across several interval ticks. A controller that drops the stalled value, strobes again while stalled, or loses or duplicates the overdue rounds shows a wrong address sequence when the bench drains the FIFO.

// File: rtl/mon_poller_pkg.sv
package mon_poller_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PUSH
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic push;
    logic hiPrio;
  } pollStrobe_t;

endpackage

// File: rtl/mon_poller_ctrl.sv
module mon_poller_ctrl
  import mon_poller_pkg::*;
#(
  parameter int NUM_PER  = 8,
  parameter int NUM_IRQ  = 2,
  parameter int ADDR_W   = 4,
  parameter int INTERVAL = 200,
  parameter int READ_LAT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               fifoFull,
  output logic               monSample,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [NUM_IRQ-1:0] irqPendOut,
  output pollStrobe_t        strobes
);

  localparam int TICK_W = $clog2(INTERVAL);
  localparam int LAT_W  = $clog2(READ_LAT + 1);
  localparam int SLOT_W = $clog2(NUM_PER);
  localparam int IRQ_W  = $clog2(NUM_IRQ);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_PER - 1);

  pollState_t         state;
  logic [TICK_W-1:0]  tickCnt;
  logic [LAT_W-1:0]   latCnt;
  logic [SLOT_W-1:0]  schedIdx;
  logic [IRQ_W-1:0]   curIrq;
  logic [IRQ_W-1:0]   irqSel;
  logic [NUM_IRQ-1:0] irqPend;
  logic [NUM_IRQ-1:0] clrMask;
  logic roundPending, inRound, curPrio, sampleQ;
  logic tick, irqAny, startRound, doPush, doCapture;

  assign tick       = (tickCnt == TICK_W'(INTERVAL - 1));
  assign irqAny     = |irqPend;
  assign startRound = (state == ST_IDLE) && !irqAny && !inRound && roundPending;
  assign doCapture  = (state == ST_WAIT) && (latCnt == LAT_W'(READ_LAT));
  assign doPush     = (state == ST_PUSH) && !fifoFull;

  // lowest pending index wins
  always_comb begin
    irqSel = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqPend[i]) irqSel = IRQ_W'(i);
    end
  end

  always_comb begin
    clrMask = '0;
    if (doPush && curPrio) clrMask[curIrq] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      tickCnt      <= '0;
      latCnt       <= '0;
      schedIdx     <= '0;
      curIrq       <= '0;
      irqPend      <= '0;
      roundPending <= 1'b0;
      inRound      <= 1'b0;
      curPrio      <= 1'b0;
      curAddr      <= '0;
      sampleQ      <= 1'b0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      irqPend <= (irqPend & ~clrMask) | irqReq;
      if (tick) roundPending <= 1'b1;
      else if (startRound) roundPending <= 1'b0;
      sampleQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (irqAny) begin
            curAddr <= ADDR_W'(NUM_PER) + ADDR_W'(irqSel);
            curIrq  <= irqSel;
            curPrio <= 1'b1;
            sampleQ <= 1'b1;
            latCnt  <= '0;
            state   <= ST_WAIT;
          end else if (inRound || roundPending) begin
            if (inRound) begin
              curAddr <= ADDR_W'(schedIdx);
            end else begin
              curAddr  <= '0;
              schedIdx <= '0;
              inRound  <= 1'b1;
            end
            curPrio <= 1'b0;
            sampleQ <= 1'b1;
            latCnt  <= '0;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (doCapture) state <= ST_PUSH;
          else latCnt <= latCnt + 1'b1;
        end
        ST_PUSH: begin
          if (doPush) begin
            state <= ST_IDLE;
            if (!curPrio) begin
              if (schedIdx == LAST_SLOT) begin
                inRound  <= 1'b0;
                schedIdx <= '0;
              end else begin
                schedIdx <= schedIdx + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign monSample       = sampleQ;
  assign irqPendOut      = irqPend;
  assign strobes.capture = doCapture;
  assign strobes.push    = doPush;
  assign strobes.hiPrio  = curPrio;

endmodule

// File: rtl/mon_poller_dp.sv
module mon_poller_dp
  import mon_poller_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pollStrobe_t                strobes,
  input  logic [ADDR_W-1:0]          curAddr,
  input  logic [DATA_W-1:0]          monData,
  input  logic                       fifoPop,
  output logic                       fifoFull,
  output logic                       fifoEmpty,
  output logic [ADDR_W+DATA_W:0]     fifoData
);

  localparam int ENTRY_W = 1 + ADDR_W + DATA_W;
  localparam int PTR_W   = $clog2(FIFO_DEPTH);

  logic [DATA_W-1:0]  holdReg;
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W:0]     wrPtr, rdPtr;
  logic               doPop;

  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                     (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign doPop     = fifoPop && !fifoEmpty;
  assign fifoData  = mem[rdPtr[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      if (strobes.capture) holdReg <= monData;
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (doPop) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr[PTR_W-1:0]] <= {strobes.hiPrio, curAddr, holdReg};
  end

endmodule

// File: rtl/mon_poller.sv
module mon_poller
  import mon_poller_pkg::*;
#(
  parameter int NUM_PER    = 8,
  parameter int NUM_IRQ    = 2,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int INTERVAL   = 200,
  parameter int READ_LAT   = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_IRQ-1:0]     irqReq,
  output logic                   monSample,
  output logic [ADDR_W-1:0]      monAddr,
  input  logic [DATA_W-1:0]      monData,
  input  logic                   fifoPop,
  output logic                   fifoEmpty,
  output logic [ADDR_W+DATA_W:0] fifoData
);

  pollStrobe_t        strobes;
  logic               fifoFull;
  logic [ADDR_W-1:0]  curAddr;
  logic [NUM_IRQ-1:0] irqPend;

  mon_poller_ctrl #(
    .NUM_PER(NUM_PER), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W),
    .INTERVAL(INTERVAL), .READ_LAT(READ_LAT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .fifoFull(fifoFull),
    .monSample(monSample), .curAddr(curAddr), .irqPendOut(irqPend),
    .strobes(strobes)
  );

  mon_poller_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curAddr(curAddr),
    .monData(monData), .fifoPop(fifoPop), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .fifoData(fifoData)
  );

  assign monAddr = curAddr;

endmodule

// File: rtl/mon_poller_chk.sv
module mon_poller_chk #(
  parameter int NUM_PER = 8,
  parameter int NUM_IRQ = 2,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               monSample,
  input logic [ADDR_W-1:0]  monAddr,
  input logic               fifoWr,
  input logic               fifoFull,
  input logic               wrPrio,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [NUM_IRQ-1:0] irqPend
);

  // R3: strobe lasts one cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    monSample |=> !monSample);

  // R7: address changes only together with a new strobe
  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(monAddr) |-> monSample);

  // R7: never write into a full FIFO
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> !fifoFull);

  // R4: priority tag follows the source address range
  a_r4_prio_tag: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> (wrPrio == (wrAddr >= ADDR_W'(NUM_PER))));

  // R5: a pending request clears only after its write
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_pend
    a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqPend[g]) |-> $past(fifoWr));
  end

endmodule

bind mon_poller mon_poller_chk #(
  .NUM_PER(NUM_PER), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .monSample(monSample), .monAddr(monAddr),
  .fifoWr(strobes.push), .fifoFull(fifoFull), .wrPrio(strobes.hiPrio),
  .wrAddr(curAddr), .irqPend(irqPend)
);

// File: tb/test_mon_poller.sv
`timescale 1ns/1ps
module test_mon_poller;

  localparam int NUM_PER = 4;
  localparam int NUM_IRQ = 3;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int INTERVAL = 64;
  localparam int ENTRY_W = 1 + ADDR_W + DATA_W;

  // expected {priority, address}: pre-emption run then simultaneous requests
  localparam logic [4:0] EXP [9] = '{
    5'b0_0000, 5'b0_0001, 5'b1_0100, 5'b1_0110, 5'b0_0010, 5'b0_0011,
    5'b1_0100, 5'b1_0101, 5'b1_0110
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IRQ-1:0] irqReq = '0;
  logic monSample;
  logic [ADDR_W-1:0] monAddr;
  logic [DATA_W-1:0] monData;
  logic fifoPop = 1'b0;
  logic fifoEmpty;
  logic [ENTRY_W-1:0] fifoData;

  int checkCount = 0;
  int failCount = 0;
  int popIdx = 0;
  int cyc = 0;
  int strobeCount;
  logic [1:0] dly;
  logic [3:0] serial;
  logic [7:0] latched;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mon_poller #(
    .NUM_PER(NUM_PER), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INTERVAL(INTERVAL), .READ_LAT(2), .FIFO_DEPTH(4)
  ) i_mon_poller (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .monSample(monSample),
    .monAddr(monAddr), .monData(monData), .fifoPop(fifoPop),
    .fifoEmpty(fifoEmpty), .fifoData(fifoData)
  );

  // monitor model: reading valid only in the cycle two after the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dly <= '0; serial <= '0; latched <= '0; strobeCount <= 0;
    end else begin
      dly <= {dly[0], monSample};
      if (monSample) begin
        latched     <= {monAddr, serial};
        serial      <= serial + 1'b1;
        strobeCount <= strobeCount + 1;
      end
    end
  end
  assign monData = dly[1] ? latched : ~latched;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic popCheck(input logic prio, input logic [3:0] addr, input string req);
    logic [ENTRY_W-1:0] want;
    while (fifoEmpty) @(negedge clk);
    want = {prio, addr, addr, 4'(popIdx)};
    check(fifoData == want, req, "fifo entry", int'(fifoData), int'(want));
    popIdx++;
    fifoPop = 1'b1;
    @(negedge clk);
    fifoPop = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(monSample == 1'b0, "R1", "sample in reset", int'(monSample), 0);
    check(monAddr == '0, "R1", "address in reset", int'(monAddr), 0);
    check(fifoEmpty == 1'b1, "R1", "fifo empty in reset", int'(fifoEmpty), 1);
    popIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitStrobe(input logic [3:0] addr);
    @(negedge clk);
    while (!(monSample && monAddr == addr)) @(negedge clk);
  endtask

  initial begin
    int s0, t0, t1;
    doReset();

    // R6 R5 R4 R3: requests 0 and 2 raised during scheduled read of slot 1
    waitStrobe(4'd1);
    irqReq = 3'b101;
    @(negedge clk);
    irqReq = '0;
    for (int i = 0; i < 6; i++) popCheck(EXP[i][4], EXP[i][3:0], "R6");

    // R7: leave FIFO full across several ticks
    s0 = strobeCount;
    while (strobeCount < s0 + 5) @(negedge clk);
    repeat (150) @(negedge clk);
    check(strobeCount == s0 + 5, "R7", "strobes while full", strobeCount - s0, 5);
    check(monAddr == 4'd0, "R7", "address held while full", int'(monAddr), 0);
    for (int i = 0; i < 12; i++) popCheck(1'b0, 4'(i % 4), "R7");

    // R2: round starts INTERVAL cycles apart
    doReset();
    waitStrobe(4'd0);
    t0 = cyc;
    @(negedge clk);
    waitStrobe(4'd0);
    t1 = cyc;
    check(t1 - t0 == INTERVAL, "R2", "round spacing", t1 - t0, INTERVAL);

    // R5 R8: all requests at once while idle
    doReset();
    repeat (5) @(negedge clk);
    irqReq = 3'b111;
    @(negedge clk);
    irqReq = '0;
    for (int i = 6; i < 9; i++) popCheck(EXP[i][4], EXP[i][3:0], "R5");
    check(fifoEmpty == 1'b1, "R8", "fifo drained", int'(fifoEmpty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule